// File: doc/BRIEF.md
# CEC Receive Error-Bit Policy

This block sits between the receive bit decoder of a CEC line controller and the open-drain line driver. The decoder reports three kinds of receive fault as single-cycle pulses: a rising edge at the wrong moment inside a bit, a bit period that is too short, and a bit period that is too long. For each fault the block decides two things. The first is whether the current reception must be abandoned. The second is whether an error bit must be driven onto the shared line to warn the other devices.

The decision depends on a small set of static configuration bits: abort-on-rising-fault, error-bit enables for rising faults and long-period faults, and a broadcast override. When the frame being received is a broadcast, the override replaces the per-fault enables with its own rules. The override either suppresses all error bits, or inverts the sense of the per-fault enables. When it inverts them, one extra rule applies to short-period faults: no error bit is sent while the receiver is in full listen mode. Each fault also sets a sticky flag. Software clears a flag by writing 1 to it.

The line driver turns each request into a low pulse of about 1.5 nominal bit periods. This block only issues the one-cycle request.

Top module: `cec_rxerr_policy`

## Requirements
- R1: `rx_stop` pulses one cycle after a rising fault when `cfg_stop_rise` is 1. It does not pulse for a rising fault alone when `cfg_stop_rise` is 0. A short-period or long-period fault always causes an `rx_stop` pulse one cycle later.
- R2: On a non-broadcast frame (`frame_bcast`=0), a rising fault requests an error bit only when both `cfg_stop_rise` and `cfg_gen_rise` are 1.
- R3: On a non-broadcast frame, a long-period fault requests an error bit exactly when `cfg_gen_long` is 1.
- R4: On a non-broadcast frame, a short-period fault always requests an error bit.
- R5: On a broadcast frame with `cfg_bcast_quiet`=0, a rising fault requests an error bit exactly when `cfg_stop_rise` is 1 and `cfg_gen_rise` is 0.
- R6: On a broadcast frame with `cfg_bcast_quiet`=0, a long-period fault requests an error bit exactly when `cfg_gen_long` is 0.
- R7: On a broadcast frame with `cfg_bcast_quiet`=0, a short-period fault requests an error bit exactly when `listen_full` is 0.
- R8: On a broadcast frame with `cfg_bcast_quiet`=1, no fault requests an error bit.
- R9: `err_flags` bit 0 (rising), bit 1 (short) and bit 2 (long) are set one cycle after their fault. Each stays set until a cycle in which the same bit of `flag_clr` is 1. A fault in that same cycle wins over the clear.
- R10: `errbit_req` and `rx_stop` are registered, are 0 after reset, and are 1 only in the cycle after a cycle that carries a fault. All flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_rise | input | 1 | Rising-fault pulse from the bit decoder |
| flt_short | input | 1 | Short-period fault pulse |
| flt_long | input | 1 | Long-period fault pulse |
| frame_bcast | input | 1 | Current frame is a broadcast |
| listen_full | input | 1 | Receiver is in full listen mode |
| cfg_stop_rise | input | 1 | Abort reception on a rising fault |
| cfg_gen_rise | input | 1 | Error-bit enable for rising faults |
| cfg_gen_long | input | 1 | Error-bit enable for long-period faults |
| cfg_bcast_quiet | input | 1 | Suppress all error bits on broadcast frames |
| flag_clr | input | 3 | Write-1-to-clear for the sticky flags |
| rx_stop | output | 1 | One-cycle request to abandon reception |
| errbit_req | output | 1 | One-cycle request to the line driver for an error bit |
| err_flags | output | 3 | Sticky fault flags {long, short, rising} |

## Verification
The hardest situations to reach are the broadcast cases in which the per-fault enables flip meaning. The short-period listen-mode exception is one of them: it shows only when a broadcast frame, full listen mode and an unsuppressed override all coincide with a short fault. The bench reaches every such case by sweeping all 64 settings of the six mode and configuration inputs against all seven non-empty combinations of simultaneous faults. For each case the expected abort and error-bit outcome is computed from the rules. Directed steps then cover the same-cycle conflict between a fault and a flag clear.

// File: rtl/cec_rxerr_pkg.sv
package cec_rxerr_pkg;
  localparam int unsigned NUM_FLT = 3;
  typedef enum logic [1:0] {
    FLT_RISE  = 2'd0,
    FLT_SHORT = 2'd1,
    FLT_LONG  = 2'd2
  } flt_idx_e;
  typedef struct packed {
    logic stop_rise;
    logic gen_rise;
    logic gen_long;
    logic bcast_quiet;
  } policy_cfg_t;
endpackage

// File: rtl/cec_rxerr_decide.sv
module cec_rxerr_decide
  import cec_rxerr_pkg::*;
(
  input  logic [NUM_FLT-1:0] flt,
  input  logic               bcast,
  input  logic               listen_full,
  input  policy_cfg_t        cfg,
  output logic               stop,
  output logic               errbit
);
  logic [NUM_FLT-1:0] allow;

  always_comb begin
    stop = (flt[FLT_RISE] & cfg.stop_rise) | flt[FLT_SHORT] | flt[FLT_LONG];
    allow = '0;
    if (!bcast) begin
      allow[FLT_RISE]  = cfg.stop_rise & cfg.gen_rise;
      allow[FLT_SHORT] = 1'b1;
      allow[FLT_LONG]  = cfg.gen_long;
    end else if (!cfg.bcast_quiet) begin
      allow[FLT_RISE]  = cfg.stop_rise & ~cfg.gen_rise;
      allow[FLT_SHORT] = ~listen_full;
      allow[FLT_LONG]  = ~cfg.gen_long;
    end
    errbit = |(flt & allow);
  end
endmodule

// File: rtl/cec_rxerr_sticky.sv
module cec_rxerr_sticky #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] flags
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr[i]) |=> flags[i]);
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/cec_rxerr_policy.sv
module cec_rxerr_policy
  import cec_rxerr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               flt_rise,
  input  logic               flt_short,
  input  logic               flt_long,
  input  logic               frame_bcast,
  input  logic               listen_full,
  input  logic               cfg_stop_rise,
  input  logic               cfg_gen_rise,
  input  logic               cfg_gen_long,
  input  logic               cfg_bcast_quiet,
  input  logic [NUM_FLT-1:0] flag_clr,
  output logic               rx_stop,
  output logic               errbit_req,
  output logic [NUM_FLT-1:0] err_flags
);
  logic [NUM_FLT-1:0] flt_vec;
  policy_cfg_t        cfg;
  logic               stop_d;
  logic               errbit_d;

  assign flt_vec = {flt_long, flt_short, flt_rise};
  assign cfg = '{stop_rise: cfg_stop_rise, gen_rise: cfg_gen_rise,
                 gen_long: cfg_gen_long, bcast_quiet: cfg_bcast_quiet};

  cec_rxerr_decide u_decide (
    .flt        (flt_vec),
    .bcast      (frame_bcast),
    .listen_full(listen_full),
    .cfg        (cfg),
    .stop       (stop_d),
    .errbit     (errbit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_stop    <= 1'b0;
      errbit_req <= 1'b0;
    end else begin
      rx_stop    <= stop_d;
      errbit_req <= errbit_d;
    end
  end

  cec_rxerr_sticky #(.WIDTH(NUM_FLT)) u_sticky (
    .clk  (clk),
    .rst  (rst),
    .set  (flt_vec),
    .clr  (flag_clr),
    .flags(err_flags)
  );

  assert_no_stop_rise_R1: assert property (@(posedge clk) disable iff (rst)
    (flt_rise && !cfg_stop_rise && !flt_short && !flt_long) |=> !rx_stop);
  assert_period_stop_R1: assert property (@(posedge clk) disable iff (rst)
    (flt_short || flt_long) |=> rx_stop);
  assert_long_gen_R3: assert property (@(posedge clk) disable iff (rst)
    (!frame_bcast && flt_long && !cfg_gen_long && !flt_rise && !flt_short) |=> !errbit_req);
  assert_short_gen_R4: assert property (@(posedge clk) disable iff (rst)
    (!frame_bcast && flt_short) |=> errbit_req);
  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_bcast && cfg_bcast_quiet) |=> !errbit_req);
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!flt_rise && !flt_short && !flt_long) |=> (!errbit_req && !rx_stop));
endmodule

// File: tb/cec_rxerr_policy_test.sv
module cec_rxerr_policy_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt_rise = 0, flt_short = 0, flt_long = 0;
  logic frame_bcast = 0, listen_full = 0;
  logic cfg_stop_rise = 0, cfg_gen_rise = 0, cfg_gen_long = 0, cfg_bcast_quiet = 0;
  logic [2:0] flag_clr = 3'b000;
  logic rx_stop, errbit_req;
  logic [2:0] err_flags;
  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cec_rxerr_policy uut (
    .clk(clk), .rst(rst), .flt_rise(flt_rise), .flt_short(flt_short), .flt_long(flt_long),
    .frame_bcast(frame_bcast), .listen_full(listen_full), .cfg_stop_rise(cfg_stop_rise),
    .cfg_gen_rise(cfg_gen_rise), .cfg_gen_long(cfg_gen_long), .cfg_bcast_quiet(cfg_bcast_quiet),
    .flag_clr(flag_clr), .rx_stop(rx_stop), .errbit_req(errbit_req), .err_flags(err_flags)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected outcome written from the rule list, one error kind at a time
  function automatic bit exp_gen(input int kind, input bit bc, input bit lf,
                                 input bit sr, input bit gr, input bit gl, input bit q);
    bit r;
    r = 0;
    case (kind)
      0: r = bc ? (!q && sr && !gr) : (sr && gr);   // R2 / R5
      1: r = bc ? (!q && !lf) : 1'b1;               // R4 / R7
      2: r = bc ? (!q && !gl) : gl;                 // R3 / R6
      default: r = 0;
    endcase
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10", rx_stop, 0, "rx_stop after reset");
    chk("R10", errbit_req, 0, "errbit_req after reset");
    chk("R9", err_flags, 0, "flags after reset");

    // exhaustive sweep: 7 fault combinations x 64 configurations
    for (int m = 1; m < 8; m++) begin
      for (int c = 0; c < 64; c++) begin
        bit e_stop, e_gen;
        frame_bcast = c[0]; listen_full = c[1]; cfg_stop_rise = c[2];
        cfg_gen_rise = c[3]; cfg_gen_long = c[4]; cfg_bcast_quiet = c[5];
        flt_rise = m[0]; flt_short = m[1]; flt_long = m[2];
        flag_clr = 3'b000;
        e_stop = (m[0] && c[2]) || m[1] || m[2];
        e_gen = 0;
        for (int k = 0; k < 3; k++)
          if (m[k] && exp_gen(k, c[0], c[1], c[2], c[3], c[4], c[5])) e_gen = 1;
        @(negedge clk);
        chk("R1", rx_stop, e_stop, $sformatf("stop m=%0d c=%0d", m, c));
        if (c[0] && c[5])
          chk("R8", errbit_req, 0, $sformatf("quiet m=%0d c=%0d", m, c));
        else if (c[0])
          chk("R5_R6_R7", errbit_req, e_gen, $sformatf("bcast m=%0d c=%0d", m, c));
        else
          chk("R2_R3_R4", errbit_req, e_gen, $sformatf("direct m=%0d c=%0d", m, c));
        chk("R9", err_flags, m, $sformatf("flags set m=%0d", m));
        flt_rise = 0; flt_short = 0; flt_long = 0; flag_clr = 3'b111;
        @(negedge clk);
        chk("R10", rx_stop, 0, "stop single cycle");
        chk("R10", errbit_req, 0, "errbit single cycle");
        chk("R9", err_flags, 0, "flags cleared");
        flag_clr = 3'b000;
      end
    end

    // directed: sticky hold, partial clear, set beats clear
    frame_bcast = 0; listen_full = 0; cfg_stop_rise = 0; cfg_gen_rise = 0;
    cfg_gen_long = 0; cfg_bcast_quiet = 0;
    flt_rise = 1; flt_long = 1;
    @(negedge clk);
    flt_rise = 0; flt_long = 0;
    repeat (3) @(negedge clk);
    chk("R9", err_flags, 3'b101, "flags hold");
    flag_clr = 3'b001;
    @(negedge clk);
    chk("R9", err_flags, 3'b100, "partial clear");
    flag_clr = 3'b010; flt_short = 1;
    @(negedge clk);
    chk("R9", err_flags, 3'b110, "set wins over clear");
    chk("R4", errbit_req, 1, "short on direct frame");
    flt_short = 0; flag_clr = 3'b000;
    @(negedge clk);
    chk("R10", errbit_req, 0, "idle after short");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule